// File: doc/BRIEF.md
# Multi-Latency Execute Cluster

This block is the execute stage of an in-order pipeline. One issue point feeds four parallel lanes whose depths differ. Each issued operation carries three things: a unit select, a destination register tag and a data payload. It enters the lane that its select names. The integer, add and multiply lanes are plain shift pipelines that accept a new operation on every cycle. The divide lane is a single unpipelined slot, guarded by a busy flag and a countdown. Each lane reports its result on its own slice of the result port, at a fixed latency after issue. A short operation issued late can therefore complete before a long operation issued earlier.

No real arithmetic is done. Each lane applies a trivial transform to the payload so that the lane a result came from can be told from its data:
- integer adds 1;
- add adds 3;
- multiply shifts left by one;
- divide inverts every bit.

Hazard logic in the issue stage can see the valid bit and destination tag of every stage register through a flat stage bus. It can also see the divide busy flag. A kill input retires a named divide that is in flight without letting it write a result. A divide request made while the divide slot is occupied is dropped and sets a sticky error flag.

Top module: `fp_exec_cluster`

## Requirements
- R1: Reset clears every stage valid bit, every result valid bit, the divide busy flag and the sticky error flag.
- R2: An operation issued with unit select 0 (integer) appears on result lane 0 in the cycle after its issue edge. It carries its tag and the payload plus 1.
- R3: An operation with unit select 1 (add) appears on result lane 1 four cycles after its issue edge, counting the issue edge as the first. It carries the payload plus 3. The add lane accepts an operation on every cycle.
- R4: An operation with unit select 2 (multiply) appears on result lane 2 seven cycles after its issue edge. It carries the payload shifted left by one bit. The multiply lane accepts an operation on every cycle.
- R5: An operation with unit select 3 (divide), issued while the lane is idle, appears on result lane 3 twenty-five cycles after its issue edge. It carries the bitwise inverse of the payload. The divide busy flag is high from the issue edge through the result cycle.
- R6: A divide request made while the busy flag is high is dropped and sets the error flag. The dropped request never produces a result. The error flag stays high until reset.
- R7: A kill whose tag equals the tag of the divide in flight clears that divide's valid bit, so it produces no result. The busy flag still runs its full duration. A kill with a different tag has no effect.
- R8: The stage bus has 13 positions:
  - position 0 is the integer stage;
  - positions 1 to 4 are the add stages, first to last;
  - positions 5 to 11 are the multiply stages, first to last;
  - position 12 is the divide slot.
  Each position shows a valid bit and a 5-bit tag, with position p's tag at bits 5p+4 down to 5p. An operation occupies stage k of its lane k+1 cycles after its issue edge.
- R9: Results leave in completion order, not issue order. When a multiply, an add and an integer operation are issued on consecutive cycles, the integer result arrives first and the multiply result arrives last.
- R10: Up to 4 add operations and up to 7 multiply operations can be in flight at once, each shown valid in its own stage position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Issue request |
| issue_unit | input | 2 | Lane select: 0 integer, 1 add, 2 multiply, 3 divide |
| issue_tag | input | 5 | Destination register tag |
| issue_data | input | 16 | Payload |
| kill_valid | input | 1 | Kill request for the divide in flight |
| kill_tag | input | 5 | Tag of the divide to kill |
| div_busy | output | 1 | Divide slot occupied |
| err_flag | output | 1 | Sticky flag for a divide issued while busy |
| res_valid | output | 4 | Result valid, one bit per lane |
| res_tag | output | 20 | Result tags, lane l at bits 5l+4:5l |
| res_data | output | 64 | Result data, lane l at bits 16l+15:16l |
| stage_valid | output | 13 | Valid bit of every stage position |
| stage_tag | output | 65 | Tag of every stage position |

## Verification
Every lane is a chain of registers, so any fault inside a lane shows up at the ports within that lane's own depth. A lost or shifted stage moves a result's arrival cycle, drops a valid bit on the stage bus one cycle after the bad stage, or corrupts the tag at a known position. A divide countdown that is off by one, or a busy flag that clears early, shows within 25 cycles: the divide result appears in the wrong cycle, or a second divide is accepted or refused against the expected error flag. The bench compares every lane's result against a cycle-indexed reference on every cycle, so an ordering fault between lanes shows up at the first completion that is out of place.

// File: rtl/exec_pkg.sv
package exec_pkg;
   typedef enum logic [1:0] {
      UNIT_INT = 2'd0,
      UNIT_ADD = 2'd1,
      UNIT_MUL = 2'd2,
      UNIT_DIV = 2'd3
   } unit_e;

   localparam int NUM_LANES = 4;

   // Payload transform selectors, one per lane kind
   localparam int XF_INC = 0;
   localparam int XF_ADD3 = 1;
   localparam int XF_SHL = 2;
   localparam int XF_INV = 3;
endpackage

// File: rtl/exec_pipe.sv
module exec_pipe #(
   parameter int DEPTH = 4,
   parameter int TW = 5,
   parameter int DW = 16,
   parameter int XFORM = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_v,
   input  logic [TW-1:0]    in_tag,
   input  logic [DW-1:0]    in_data,
   output logic [DEPTH-1:0] stg_v,
   output logic [DEPTH*TW-1:0] stg_tag,
   output logic             out_v,
   output logic [TW-1:0]    out_tag,
   output logic [DW-1:0]    out_data
);
   logic [DEPTH-1:0]         v_q, v_d;
   logic [DEPTH-1:0][TW-1:0] t_q, t_d;
   logic [DEPTH-1:0][DW-1:0] d_q, d_d;

   always_comb begin
      v_d[0] = in_v;
      t_d[0] = in_tag;
      d_d[0] = in_data;
      for (int s = 1; s < DEPTH; s++) begin
         v_d[s] = v_q[s-1];
         t_d[s] = t_q[s-1];
         d_d[s] = d_q[s-1];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q <= '0;
         t_q <= '0;
         d_q <= '0;
      end else begin
         v_q <= v_d;
         t_q <= t_d;
         d_q <= d_d;
      end
   end

   assign stg_v   = v_q;
   assign stg_tag = t_q;
   assign out_v   = v_q[DEPTH-1];
   assign out_tag = t_q[DEPTH-1];

   generate
      if (XFORM == exec_pkg::XF_INC) begin : g_inc
         assign out_data = d_q[DEPTH-1] + DW'(1);
      end else if (XFORM == exec_pkg::XF_ADD3) begin : g_add3
         assign out_data = d_q[DEPTH-1] + DW'(3);
      end else if (XFORM == exec_pkg::XF_SHL) begin : g_shl
         assign out_data = {d_q[DEPTH-1][DW-2:0], 1'b0};
      end else begin : g_inv
         assign out_data = ~d_q[DEPTH-1];
      end
   endgenerate
endmodule

// File: rtl/exec_div.sv
module exec_div #(
   parameter int LAT = 25,
   parameter int TW = 5,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_v,
   input  logic [TW-1:0] in_tag,
   input  logic [DW-1:0] in_data,
   input  logic          kill_v,
   input  logic [TW-1:0] kill_tag,
   output logic          busy,
   output logic          collide,
   output logic          stg_v,
   output logic [TW-1:0] stg_tag,
   output logic          out_v,
   output logic [TW-1:0] out_tag,
   output logic [DW-1:0] out_data
);
   localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

   logic          busy_q, v_q;
   logic [CW-1:0] cnt_q;
   logic [TW-1:0] t_q;
   logic [DW-1:0] d_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         v_q    <= 1'b0;
         cnt_q  <= '0;
         t_q    <= '0;
         d_q    <= '0;
      end else if (in_v && !busy_q) begin
         busy_q <= 1'b1;
         v_q    <= 1'b1;
         cnt_q  <= CW'(LAT - 1);
         t_q    <= in_tag;
         d_q    <= in_data;
      end else if (busy_q) begin
         if (cnt_q == '0) begin
            busy_q <= 1'b0;
            v_q    <= 1'b0;
         end else begin
            cnt_q <= cnt_q - CW'(1);
         end
         if (kill_v && kill_tag == t_q) begin
            v_q <= 1'b0;
         end
      end
   end

   assign busy     = busy_q;
   assign collide  = in_v && busy_q;
   assign stg_v    = v_q;
   assign stg_tag  = t_q;
   assign out_v    = busy_q && v_q && (cnt_q == '0);
   assign out_tag  = t_q;
   assign out_data = ~d_q;
endmodule

// File: rtl/fp_exec_cluster.sv
module fp_exec_cluster #(
   parameter int TAG_W = 5,
   parameter int DATA_W = 16,
   parameter int ADD_DEPTH = 4,
   parameter int MUL_DEPTH = 7,
   parameter int DIV_LAT = 25,
   localparam int NSTG = 1 + ADD_DEPTH + MUL_DEPTH + 1,
   localparam int NL = exec_pkg::NUM_LANES
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  issue_valid,
   input  logic [1:0]            issue_unit,
   input  logic [TAG_W-1:0]      issue_tag,
   input  logic [DATA_W-1:0]     issue_data,
   input  logic                  kill_valid,
   input  logic [TAG_W-1:0]      kill_tag,
   output logic                  div_busy,
   output logic                  err_flag,
   output logic [NL-1:0]         res_valid,
   output logic [NL*TAG_W-1:0]   res_tag,
   output logic [NL*DATA_W-1:0]  res_data,
   output logic [NSTG-1:0]       stage_valid,
   output logic [NSTG*TAG_W-1:0] stage_tag
);
   import exec_pkg::*;

   localparam int DIV_POS = NSTG - 1;

   function automatic int lane_depth(int l);
      case (l)
         0: return 1;
         1: return ADD_DEPTH;
         default: return MUL_DEPTH;
      endcase
   endfunction

   function automatic int lane_off(int l);
      case (l)
         0: return 0;
         1: return 1;
         default: return 1 + ADD_DEPTH;
      endcase
   endfunction

   generate
      if (ADD_DEPTH < 1) begin : g_bad_add
         $error("ADD_DEPTH must be at least 1");
      end
      if (MUL_DEPTH < 1) begin : g_bad_mul
         $error("MUL_DEPTH must be at least 1");
      end
      if (DIV_LAT < 2) begin : g_bad_div
         $error("DIV_LAT must be at least 2");
      end
      if (TAG_W < 1 || DATA_W < 2) begin : g_bad_w
         $error("TAG_W or DATA_W too small");
      end
   endgenerate

   logic [NL-1:0] lane_go;
   always_comb begin
      for (int l = 0; l < NL; l++) begin
         lane_go[l] = issue_valid && (issue_unit == 2'(l));
      end
   end

   // Pipelined lanes: integer, add, multiply
   for (genvar l = 0; l < 3; l++) begin : g_lane
      localparam int D = lane_depth(l);
      localparam int O = lane_off(l);
      exec_pipe #(
         .DEPTH(D), .TW(TAG_W), .DW(DATA_W), .XFORM(l)
      ) pipe_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .in_v     (lane_go[l]),
         .in_tag   (issue_tag),
         .in_data  (issue_data),
         .stg_v    (stage_valid[O +: D]),
         .stg_tag  (stage_tag[O*TAG_W +: D*TAG_W]),
         .out_v    (res_valid[l]),
         .out_tag  (res_tag[l*TAG_W +: TAG_W]),
         .out_data (res_data[l*DATA_W +: DATA_W])
      );
   end

   logic div_collide;

   exec_div #(
      .LAT(DIV_LAT), .TW(TAG_W), .DW(DATA_W)
   ) div_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_v     (lane_go[UNIT_DIV]),
      .in_tag   (issue_tag),
      .in_data  (issue_data),
      .kill_v   (kill_valid),
      .kill_tag (kill_tag),
      .busy     (div_busy),
      .collide  (div_collide),
      .stg_v    (stage_valid[DIV_POS]),
      .stg_tag  (stage_tag[DIV_POS*TAG_W +: TAG_W]),
      .out_v    (res_valid[3]),
      .out_tag  (res_tag[3*TAG_W +: TAG_W]),
      .out_data (res_data[3*DATA_W +: DATA_W])
   );

   logic err_q;
   always_ff @(posedge clk) begin
      if (!rst_n) err_q <= 1'b0;
      else if (div_collide) err_q <= 1'b1;
   end
   assign err_flag = err_q;
endmodule

// File: rtl/exec_cluster_chk.sv
module exec_cluster_chk #(
   parameter int TAG_W = 5,
   parameter int DATA_W = 16,
   parameter int ADD_DEPTH = 4,
   parameter int MUL_DEPTH = 7,
   parameter int DIV_LAT = 25,
   localparam int NSTG = 1 + ADD_DEPTH + MUL_DEPTH + 1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  issue_valid,
   input logic [1:0]            issue_unit,
   input logic [TAG_W-1:0]      issue_tag,
   input logic                  kill_valid,
   input logic [TAG_W-1:0]      kill_tag,
   input logic                  div_busy,
   input logic                  err_flag,
   input logic [3:0]            res_valid,
   input logic [4*TAG_W-1:0]    res_tag,
   input logic [NSTG-1:0]       stage_valid,
   input logic [NSTG*TAG_W-1:0] stage_tag
);
   localparam int DP = NSTG - 1;

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> (stage_valid == '0 && !div_busy && !err_flag && res_valid == '0));

   // R2
   int_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_unit == 2'd0) |=>
         (res_valid[0] && res_tag[TAG_W-1:0] == $past(issue_tag)));

   // R3
   for (genvar k = 0; k < ADD_DEPTH - 1; k++) begin : g_add
      add_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
         stage_valid[1+k] |=> (stage_valid[2+k] &&
            stage_tag[(2+k)*TAG_W +: TAG_W] == $past(stage_tag[(1+k)*TAG_W +: TAG_W])));
   end

   // R4
   for (genvar k = 0; k < MUL_DEPTH - 1; k++) begin : g_mul
      mul_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
         stage_valid[1+ADD_DEPTH+k] |=> (stage_valid[2+ADD_DEPTH+k] &&
            stage_tag[(2+ADD_DEPTH+k)*TAG_W +: TAG_W] ==
               $past(stage_tag[(1+ADD_DEPTH+k)*TAG_W +: TAG_W])));
   end

   // R5
   div_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_unit == 2'd3 && !div_busy) |=> (div_busy && stage_valid[DP]));

   // R5
   div_res_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid[3] |-> div_busy);

   // R6
   err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_unit == 2'd3 && div_busy) |=> err_flag);

   // R6
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag);

   // R7
   div_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kill_valid && stage_valid[DP] && kill_tag == stage_tag[DP*TAG_W +: TAG_W])
         |=> (!stage_valid[DP] && !res_valid[3]));
endmodule

bind fp_exec_cluster exec_cluster_chk #(
   .TAG_W(TAG_W), .DATA_W(DATA_W), .ADD_DEPTH(ADD_DEPTH),
   .MUL_DEPTH(MUL_DEPTH), .DIV_LAT(DIV_LAT)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .issue_valid (issue_valid),
   .issue_unit  (issue_unit),
   .issue_tag   (issue_tag),
   .kill_valid  (kill_valid),
   .kill_tag    (kill_tag),
   .div_busy    (div_busy),
   .err_flag    (err_flag),
   .res_valid   (res_valid),
   .res_tag     (res_tag),
   .stage_valid (stage_valid),
   .stage_tag   (stage_tag)
);

// File: tb/fp_exec_cluster_tb_top.sv
module fp_exec_cluster_tb_top;
   localparam int TW = 5;
   localparam int DW = 16;
   localparam int AD = 4;
   localparam int MD = 7;
   localparam int DL = 25;
   localparam int NS = 1 + AD + MD + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic issue_valid = 1'b0;
   logic [1:0] issue_unit = '0;
   logic [TW-1:0] issue_tag = '0;
   logic [DW-1:0] issue_data = '0;
   logic kill_valid = 1'b0;
   logic [TW-1:0] kill_tag = '0;
   logic div_busy, err_flag;
   logic [3:0] res_valid;
   logic [4*TW-1:0] res_tag;
   logic [4*DW-1:0] res_data;
   logic [NS-1:0] stage_valid;
   logic [NS*TW-1:0] stage_tag;

   always #5 clk = ~clk;

   fp_exec_cluster dut_i (
      .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_unit(issue_unit),
      .issue_tag(issue_tag), .issue_data(issue_data), .kill_valid(kill_valid),
      .kill_tag(kill_tag), .div_busy(div_busy), .err_flag(err_flag),
      .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
      .stage_valid(stage_valid), .stage_tag(stage_tag)
   );

   int cur = 0;
   always @(posedge clk) cur <= cur + 1;

   int checks = 0;
   int fails = 0;
   bit finished = 0;

   bit            ev [4][64];
   logic [TW-1:0] et [4][64];
   logic [DW-1:0] ed [4][64];
   int div_start = -1;
   int div_end = -2;
   logic [TW-1:0] div_tag = '0;
   bit div_live = 0;
   bit err_exp = 0;
   bit in_reset = 0;

   function automatic int lat(int u);
      case (u)
         0: return 1;
         1: return AD;
         2: return MD;
         default: return DL;
      endcase
   endfunction

   function automatic logic [DW-1:0] xf(int u, logic [DW-1:0] d);
      case (u)
         0: return d + 16'd1;
         1: return d + 16'd3;
         2: return {d[DW-2:0], 1'b0};
         default: return ~d;
      endcase
   endfunction

   function automatic string lane_req(int l);
      case (l)
         0: return "R2";
         1: return "R3";
         2: return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cur);
      end
   endtask

   task automatic clear_model();
      for (int l = 0; l < 4; l++)
         for (int s = 0; s < 64; s++) ev[l][s] = 0;
      div_start = -1;
      div_end = -2;
      div_live = 0;
      err_exp = 0;
   endtask

   task automatic compare();
      int slot;
      bit busy_m;
      slot = cur % 64;
      for (int l = 0; l < 4; l++) begin
         if (ev[l][slot] || res_valid[l]) begin
            chk(res_valid[l] == ev[l][slot], lane_req(l), "result valid",
                32'(res_valid[l]), 32'(ev[l][slot]));
            if (ev[l][slot] && res_valid[l]) begin
               chk(res_tag[l*TW +: TW] == et[l][slot], lane_req(l), "result tag",
                   32'(res_tag[l*TW +: TW]), 32'(et[l][slot]));
               chk(res_data[l*DW +: DW] == ed[l][slot], lane_req(l), "result data",
                   32'(res_data[l*DW +: DW]), 32'(ed[l][slot]));
            end
         end
         ev[l][slot] = 0;
      end
      busy_m = (cur >= div_start) && (cur <= div_end);
      if (busy_m != div_busy) chk(0, "R5", "div busy", 32'(div_busy), 32'(busy_m));
      if (err_exp != err_flag) chk(0, "R6", "error flag", 32'(err_flag), 32'(err_exp));
   endtask

   // One cycle: check outputs for the current edge, then drive the next edge
   task automatic step(bit v, int u, logic [TW-1:0] tag, logic [DW-1:0] data,
                       bit kv, logic [TW-1:0] ktag);
      int slot;
      @(negedge clk);
      compare();
      issue_valid = v;
      issue_unit  = 2'(u);
      issue_tag   = tag;
      issue_data  = data;
      kill_valid  = kv;
      kill_tag    = ktag;
      if (kv && div_live && cur >= div_start && cur < div_end && ktag == div_tag) begin
         ev[3][div_end % 64] = 0;
         div_live = 0;
      end
      if (v) begin
         if (u == 3) begin
            if (cur >= div_start && cur <= div_end) begin
               err_exp = 1;
            end else begin
               div_start = cur + 1;
               div_end = cur + DL;
               div_tag = tag;
               div_live = 1;
               slot = div_end % 64;
               ev[3][slot] = 1; et[3][slot] = tag; ed[3][slot] = xf(3, data);
            end
         end else begin
            slot = (cur + lat(u)) % 64;
            ev[u][slot] = 1; et[u][slot] = tag; ed[u][slot] = xf(u, data);
         end
      end
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(0, 0, '0, '0, 0, '0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0;
      issue_valid = 0;
      kill_valid = 0;
      clear_model();
      repeat (3) @(negedge clk);
      rst_n = 1;
   endtask

   task automatic stage_chk(int pos, logic [TW-1:0] tag, string req);
      chk(stage_valid[pos] == 1'b1, req, $sformatf("stage %0d valid", pos),
          32'(stage_valid[pos]), 32'd1);
      chk(stage_tag[pos*TW +: TW] == tag, req, $sformatf("stage %0d tag", pos),
          32'(stage_tag[pos*TW +: TW]), 32'(tag));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog run did not finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] lf;
      int tgt;
      clear_model();
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1: reset state
      @(negedge clk);
      chk(stage_valid == '0, "R1", "stage valid after reset", 32'(stage_valid), 0);
      chk(res_valid == '0, "R1", "result valid after reset", 32'(res_valid), 0);
      chk(!div_busy, "R1", "busy after reset", 32'(div_busy), 0);
      chk(!err_flag, "R1", "error after reset", 32'(err_flag), 0);

      // Single operation sweep over each lane and several tags/payloads (R2..R5)
      for (int u = 0; u < 4; u++) begin
         for (int t = 0; t < 3; t++) begin
            step(1, u, 5'(7 * t + u + 1), 16'(16'h1234 * (t + 1) + u), 0, '0);
            idle(lat(u) + 2);
         end
      end
      chk(1, "R2", "lane sweep done", 0, 0);

      // R8: stage positions of each lane
      step(1, 1, 5'h15, 16'h00ff, 0, '0);
      for (int k = 0; k < AD; k++) begin
         idle(1);
         stage_chk(1 + k, 5'h15, "R8");
      end
      step(1, 2, 5'h0a, 16'h8001, 0, '0);
      for (int k = 0; k < MD; k++) begin
         idle(1);
         stage_chk(1 + AD + k, 5'h0a, "R8");
      end
      step(1, 0, 5'h1f, 16'hffff, 0, '0);
      idle(1);
      stage_chk(0, 5'h1f, "R8");
      step(1, 3, 5'h03, 16'h5a5a, 0, '0);
      idle(1);
      stage_chk(NS - 1, 5'h03, "R8");
      idle(DL + 2);

      // R10: full occupancy of add and multiply lanes
      for (int i = 0; i < MD; i++) step(1, 2, 5'(i), 16'(i * 3), 0, '0);
      idle(1);
      chk($countones(stage_valid[AD+MD:AD+1]) == MD, "R10", "mul stages occupied",
          32'($countones(stage_valid[AD+MD:AD+1])), MD);
      for (int i = 0; i < AD; i++) step(1, 1, 5'(i + 8), 16'(i + 100), 0, '0);
      idle(1);
      chk($countones(stage_valid[AD:1]) == AD, "R10", "add stages occupied",
          32'($countones(stage_valid[AD:1])), AD);
      idle(MD + 2);

      // R9: out-of-order completion
      step(1, 2, 5'h11, 16'h0100, 0, '0);
      tgt = cur;
      step(1, 1, 5'h12, 16'h0200, 0, '0);
      step(1, 0, 5'h13, 16'h0300, 0, '0);
      while (cur < tgt + 3) idle(1);
      chk(res_valid[0] && !res_valid[1] && !res_valid[2], "R9", "integer first",
          32'(res_valid), 32'h1);
      while (cur < tgt + 5) idle(1);
      chk(res_valid[1] && !res_valid[2], "R9", "add before multiply",
          32'(res_valid), 32'h2);
      while (cur < tgt + 7) idle(1);
      chk(res_valid[2], "R9", "multiply last", 32'(res_valid), 32'h4);
      idle(3);

      // R6: divide while busy is dropped and sets the sticky flag
      step(1, 3, 5'h04, 16'h0f0f, 0, '0);
      idle(4);
      step(1, 3, 5'h05, 16'hf0f0, 0, '0);
      idle(1);
      chk(err_flag, "R6", "error set", 32'(err_flag), 1);
      idle(DL + 5);
      chk(err_flag, "R6", "error sticky", 32'(err_flag), 1);
      do_reset();
      @(negedge clk);
      chk(!err_flag, "R1", "error cleared by reset", 32'(err_flag), 0);

      // R7: kill with other tag ignored, matching tag suppresses result
      step(1, 3, 5'h09, 16'h1111, 0, '0);
      idle(3);
      step(0, 0, '0, '0, 1, 5'h08);
      idle(1);
      chk(stage_valid[NS-1], "R7", "non-matching kill ignored", 32'(stage_valid[NS-1]), 1);
      idle(4);
      step(0, 0, '0, '0, 1, 5'h09);
      idle(1);
      chk(!stage_valid[NS-1], "R7", "divide killed", 32'(stage_valid[NS-1]), 0);
      chk(div_busy, "R7", "busy held after kill", 32'(div_busy), 1);
      idle(DL);
      chk(!div_busy, "R7", "busy released after full duration", 32'(div_busy), 0);
      // non-killed divide still produces its result (checked by the model)
      step(1, 3, 5'h0c, 16'h2222, 1, 5'h0d);
      idle(DL + 2);

      // Mixed stream against the reference
      lf = 16'hace1;
      for (int i = 0; i < 4000; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         step(lf[1:0] != 2'b00, int'(lf[3:2]), lf[8:4], {lf[7:0], lf[15:8]},
              lf[11:9] == 3'b000, lf[12] ? div_tag : lf[14:10]);
         if (i == 2500) do_reset();
      end
      idle(DL + 2);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule